// File: doc/BRIEF.md
# Two-Wire Register-File Slave

This block is a serial slave on a two-wire bus of the SMBus/I2C kind. It watches a clock line and a data line. It answers only to its own 7-bit address and opens a byte-wide register space of 256 locations to the bus master. The space is reached through an internal pointer. Both lines are first brought into the system clock domain by synchronizer flops, and every bus event is decoded from those synchronized samples. The slave never drives a line high. It only asks for the data line to be pulled low through an open-drain enable.

The address is made of a fixed upper part and two strap inputs, so up to four such slaves can share one bus. In a write transaction, the first byte after the address loads the pointer. Every later byte is stored at the pointer, and the pointer then advances. A read transaction cannot carry a pointer byte. It returns bytes starting at whatever the pointer holds, so a master usually sets the pointer with a short write and then reads, often through a repeated start. Four identification locations at the top of the map are read-only. All other locations are plain writable bytes.

Top module: `smbus_regfile_slave`

## Requirements
- R1: A start condition (data falling while the clock is high) abandons any transfer in progress, with no store from a partially received byte, and begins address reception. A stop condition (data rising while the clock is high) returns the slave to idle.
- R2: The slave address is the seven bits 1,1,1,0,0,strapAddr[1],strapAddr[0], sent MSB first and followed by a direction bit (0 write, 1 read). On a match, the slave pulls the data line low through the ninth clock of that frame.
- R3: On an address mismatch, the slave does not pull the data line low at any time until the next start condition.
- R4: The pull-low enable changes only while the bus clock is low.
- R5: In a write transaction, the first byte after the address is acknowledged and loads the pointer. It is not stored.
- R6: Each later write byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R7: A read transaction returns the byte at the pointer, MSB first, and advances the pointer by one for each byte. The read continues while the master acknowledges.
- R8: Locations 0xF4 to 0xF7 read as 0x41, 0x00, 0x00 and 0x00. Writes to them are acknowledged but leave them unchanged, and the pointer still advances.
- R9: After the master leaves the acknowledge slot of a read byte high, the slave releases the data line and does not pull it again before a new start condition.
- R10: The pointer wraps from 0xFF to 0x00 in both reads and writes.
- R11: After reset, the pull-low enable is off, the pointer is 0x00 and every writable location holds 0x00.
- R12: A repeated start after a pointer write is followed correctly by a read from the new pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as sampled at the pad |
| sdaIn | input | 1 | Bus data line as sampled at the pad |
| strapAddr | input | 2 | Strapped low two bits of the slave address |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
Two events can collide in the same system cycle: a start condition, and the control logic moving to its next state at the end of a bit or a byte. Start detection has priority, so a partly received byte must never turn into a store. The bench provokes this by cutting a write data byte off after four bits with a repeated start, then reading the target location back and comparing it with a model in which no store took place. It also checks that the slave acknowledges the new address cleanly. Random write and read transactions, using random straps, pointers near the identification bank and pointers near the wrap point, are compared byte by byte against the same model.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

  typedef struct packed {
    logic shiftIn;
    logic rxBit;
    logic loadPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_WAIT
  } busState_t;

endpackage

// File: rtl/smbreg_ctrl.sv
module smbreg_ctrl
  import smbreg_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] strapAddr,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpStrobe_t  strobe,
  output logic       sdaPullLow
);

  localparam int CNT_W = $clog2(9);
  localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(8);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(7);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;

  // Synchronizers, idle-high reset
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclPipe[g] <= 1'b1;
          sdaPipe[g] <= 1'b1;
        end else if (g == 0) begin
          sclPipe[g] <= sclIn;
          sdaPipe[g] <= sdaIn;
        end else begin
          sclPipe[g] <= sclPipe[g-1];
          sdaPipe[g] <= sdaPipe[g-1];
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  logic startCond, stopCond, sclRise, sclFall;
  assign startCond = sclS && sclD && sdaD && !sdaS;
  assign stopCond  = sclS && sclD && !sdaD && sdaS;
  assign sclRise   = sclS && !sclD;
  assign sclFall   = !sclS && sclD;

  busState_t state, stateN;
  logic [CNT_W-1:0] bitCnt, bitCntN;
  logic firstData, firstDataN;
  logic isRead, isReadN;
  logic mstAck, mstAckN;
  logic addrHit;

  assign addrHit = (rxByte[7:1] == {ADDR_PREFIX, strapAddr});

  always_comb begin
    strobe     = '0;
    strobe.rxBit = sdaS;
    stateN     = state;
    bitCntN    = bitCnt;
    firstDataN = firstData;
    isReadN    = isRead;
    mstAckN    = mstAck;
    if (startCond) begin
      stateN     = ST_ADDR;
      bitCntN    = '0;
      firstDataN = 1'b1;
    end else if (stopCond) begin
      stateN = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise && bitCnt != BITS_FULL) begin
            strobe.shiftIn = 1'b1;
            bitCntN = bitCnt + CNT_W'(1);
          end else if (sclFall && bitCnt == BITS_FULL) begin
            if (addrHit) begin
              stateN  = ST_ADDR_ACK;
              isReadN = rxByte[0];
            end else begin
              stateN = ST_WAIT;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitCntN = '0;
            if (isRead) begin
              strobe.loadTx = 1'b1;
              stateN = ST_RD_BYTE;
            end else begin
              stateN = ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (sclRise && bitCnt != BITS_FULL) begin
            strobe.shiftIn = 1'b1;
            bitCntN = bitCnt + CNT_W'(1);
          end else if (sclFall && bitCnt == BITS_FULL) begin
            stateN = ST_WR_ACK;
            if (firstData) begin
              strobe.loadPtr = 1'b1;
              firstDataN = 1'b0;
            end else begin
              strobe.writeReg = 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            stateN  = ST_WR_BYTE;
            bitCntN = '0;
          end
        end
        ST_RD_BYTE: begin
          if (sclFall) begin
            if (bitCnt == BIT_LAST) begin
              stateN  = ST_RD_ACK;
              bitCntN = '0;
            end else begin
              strobe.shiftTx = 1'b1;
              bitCntN = bitCnt + CNT_W'(1);
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            mstAckN = !sdaS;
          end else if (sclFall) begin
            if (mstAck) begin
              strobe.loadTx = 1'b1;
              stateN  = ST_RD_BYTE;
              bitCntN = '0;
            end else begin
              stateN = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      firstData <= 1'b0;
      isRead    <= 1'b0;
      mstAck    <= 1'b0;
    end else begin
      state     <= stateN;
      bitCnt    <= bitCntN;
      firstData <= firstDataN;
      isRead    <= isReadN;
      mstAck    <= mstAckN;
    end
  end

  assign sdaPullLow = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                      ((state == ST_RD_BYTE) && !txMsb);

  // R4: open-drain enable moves only in the low clock phase
  p_pull_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdaPullLow) |-> !sclS);

  // R1: a start always lands in address reception with the line released
  p_start_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    startCond |=> (state == ST_ADDR) && !sdaPullLow);

  // R3: after a mismatch the slave stays off the line
  p_wait_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sdaPullLow);

  // R9: a master no-acknowledge ends the read
  p_nack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ACK && sclFall && !mstAck && !startCond && !stopCond)
      |=> (state == ST_WAIT));

endmodule

// File: rtl/smbreg_datapath.sv
module smbreg_datapath
  import smbreg_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter logic [PTR_W-1:0] ID_BASE  = 8'hF4,
  parameter int ID_COUNT = 4,
  parameter logic [7:0] ID_FIRST = 8'h41
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dpStrobe_t  strobe,
  output logic [7:0] rxByte,
  output logic       txMsb
);

  localparam int DEPTH    = 2 ** PTR_W;
  localparam int ID_IDX_W = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1;
  localparam logic [PTR_W-1:0] ID_LAST = PTR_W'(int'(ID_BASE) + ID_COUNT - 1);

  logic [7:0] rxShift, txShift;
  logic [PTR_W-1:0] ptr, idOff;
  logic [7:0] mem [DEPTH];
  logic [7:0] idVals [ID_COUNT];
  logic isId;
  logic [7:0] readVal;

  genvar g;
  generate
    for (g = 0; g < ID_COUNT; g++) begin : g_id
      assign idVals[g] = (g == 0) ? ID_FIRST : 8'h00;
    end
  endgenerate

  assign isId    = (ptr >= ID_BASE) && (ptr <= ID_LAST);
  assign idOff   = ptr - ID_BASE;
  assign readVal = isId ? idVals[idOff[ID_IDX_W-1:0]] : mem[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
      txShift <= '0;
      ptr     <= '0;
    end else begin
      if (strobe.shiftIn) rxShift <= {rxShift[6:0], strobe.rxBit};
      if (strobe.loadPtr) begin
        ptr <= rxShift[PTR_W-1:0];
      end else if (strobe.writeReg || strobe.loadTx) begin
        ptr <= ptr + PTR_W'(1);
      end
      if (strobe.loadTx)       txShift <= readVal;
      else if (strobe.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (strobe.writeReg && !isId) begin
      mem[ptr] <= rxShift;
    end
  end

  assign rxByte = rxShift;
  assign txMsb  = txShift[7];

  // R7/R10: every fetched byte advances the pointer, wrapping at the top
  p_ptr_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadTx |=> ptr == $past(ptr) + PTR_W'(1));

  // R6: a stored byte lands at the pointer it was received for
  p_store_at_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.writeReg && !isId) |=> mem[$past(ptr)] == $past(rxShift));

  // R8: the identification bank never takes a write
  p_id_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.writeReg && isId) |=> $stable(rxShift) && (ptr == $past(ptr) + PTR_W'(1)));

  // R5: the pointer byte is loaded, never stored
  p_ptr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadPtr |=> ptr == $past(rxShift[PTR_W-1:0]));

endmodule

// File: rtl/smbus_regfile_slave.sv
module smbus_regfile_slave
  import smbreg_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11100,
  parameter int         SYNC_STAGES = 2,
  parameter int         PTR_W       = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] strapAddr,
  output logic       sdaPullLow
);

  dpStrobe_t  strobe;
  logic [7:0] rxByte;
  logic       txMsb;

  smbreg_ctrl #(
    .ADDR_PREFIX(ADDR_PREFIX),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .strapAddr(strapAddr),
    .rxByte(rxByte),
    .txMsb(txMsb),
    .strobe(strobe),
    .sdaPullLow(sdaPullLow)
  );

  smbreg_datapath #(
    .PTR_W(PTR_W)
  ) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .strobe(strobe),
    .rxByte(rxByte),
    .txMsb(txMsb)
  );

endmodule

// File: tb/smbus_regfile_slave_tb.sv
`timescale 1ns/1ps
module smbus_regfile_slave_tb;

  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] strap = 2'b00;
  logic sdaPullLow;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaPullLow;

  always #2.5 clk = ~clk;

  smbus_regfile_slave u_dut (
    .clk(clk),
    .rst_n(rst_n),
    .sclIn(sclM),
    .sdaIn(sdaLine),
    .strapAddr(strap),
    .sdaPullLow(sdaPullLow)
  );

  int checks = 0;
  int fails = 0;
  int r4Bad = 0;
  bit finished = 0;
  logic [7:0] model [256];
  logic [7:0] mPtr = 8'h00;
  logic prevPull = 1'b0;

  function automatic logic [7:0] expRead(input logic [7:0] a);
    if (a == 8'hF4) return 8'h41;
    if (a >= 8'hF5 && a <= 8'hF7) return 8'h00;
    return model[a];
  endfunction

  function automatic bit isIdAddr(input logic [7:0] a);
    return (a >= 8'hF4) && (a <= 8'hF7);
  endfunction

  function automatic logic [7:0] myAddr(input bit rd);
    return {5'b11100, strap, rd};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R4 monitor: the enable may move only while the master holds the clock low
  always @(negedge clk) begin
    if (rst_n && (sdaPullLow != prevPull) && sclM) r4Bad++;
    prevPull <= sdaPullLow;
  end

  task automatic busStart();
    sdaM = 1'b1; wq(Q);
    sclM = 1'b1; wq(Q);
    sdaM = 1'b0; wq(Q);
    sclM = 1'b0; wq(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; wq(Q);
    sclM = 1'b1; wq(Q);
    sdaM = 1'b1; wq(2 * Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; wq(Q);
      sclM = 1'b1; wq(2 * Q);
      sclM = 1'b0; wq(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    sendBits(b, 8);
    sdaM = 1'b1; wq(Q);
    sclM = 1'b1; wq(Q);
    ack = !sdaLine; wq(Q);
    sclM = 1'b0; wq(Q);
  endtask

  task automatic recvByte(output logic [7:0] b, input bit ackIt);
    sdaM = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(Q);
      sclM = 1'b1; wq(Q);
      b = {b[6:0], sdaLine}; wq(Q);
      sclM = 1'b0;
    end
    wq(Q);
    sdaM = ackIt ? 1'b0 : 1'b1; wq(Q);
    sclM = 1'b1; wq(2 * Q);
    sclM = 1'b0; wq(Q);
    sdaM = 1'b1;
  endtask

  task automatic writeBody(input logic [7:0] p, input int n, input logic [31:0] data);
    bit ack;
    sendByte(p, ack);
    chk(ack, "R5 pointer byte ack", 32'(ack), 1);
    mPtr = p;
    for (int i = 0; i < n; i++) begin
      sendByte(data[8*i +: 8], ack);
      chk(ack, isIdAddr(mPtr) ? "R8 id write ack" : "R6 data ack", 32'(ack), 1);
      if (!isIdAddr(mPtr)) model[mPtr] = data[8*i +: 8];
      mPtr = mPtr + 8'd1;
    end
  endtask

  task automatic readBody(input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recvByte(b, i < n - 1);
      chk(b == expRead(mPtr), req, 32'(b), 32'(expRead(mPtr)));
      mPtr = mPtr + 8'd1;
    end
    // R9: extra clock after the no-acknowledge, slave must stay off the line
    wq(Q); sclM = 1'b1; wq(Q);
    chk(!sdaPullLow, "R9 released after nack", 32'(sdaPullLow), 0);
    wq(Q); sclM = 1'b0; wq(Q);
  endtask

  task automatic writeTxn(input logic [7:0] p, input int n, input logic [31:0] data);
    bit ack;
    busStart();
    sendByte(myAddr(0), ack);
    chk(ack, "R2 address ack (write)", 32'(ack), 1);
    writeBody(p, n, data);
    busStop();
  endtask

  task automatic readTxn(input int n, input string req);
    bit ack;
    busStart();
    sendByte(myAddr(1), ack);
    chk(ack, "R2 address ack (read)", 32'(ack), 1);
    readBody(n, req);
    busStop();
  endtask

  task automatic ptrThenRead(input logic [7:0] p, input int n, input string req);
    bit ack;
    busStart();
    sendByte(myAddr(0), ack);
    chk(ack, "R2 address ack", 32'(ack), 1);
    writeBody(p, 0, 32'h0);
    busStart();
    sendByte(myAddr(1), ack);
    chk(ack, "R12 address ack after repeated start", 32'(ack), 1);
    readBody(n, req);
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] p;
    int n, op;
    logic [31:0] d;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    void'($urandom(32'd4242));
    wq(5);
    chk(!sdaPullLow, "R11 released in reset", 32'(sdaPullLow), 0);
    rst_n = 1'b1;
    wq(10);
    chk(!sdaPullLow, "R11 released after reset", 32'(sdaPullLow), 0);

    // R11: pointer starts at 0x00, array cleared
    readTxn(3, "R11 reset contents");

    // R3: wrong prefix and wrong strap bits
    busStart();
    sendByte(8'hA0, ack);
    chk(!ack, "R3 prefix mismatch no ack", 32'(ack), 0);
    sendByte(8'h00, ack);
    chk(!ack, "R3 silent after mismatch", 32'(ack), 0);
    busStop();
    strap = 2'b10;
    busStart();
    sendByte({5'b11100, 2'b01, 1'b0}, ack);
    chk(!ack, "R3 strap mismatch no ack", 32'(ack), 0);
    busStop();

    // R6/R7 plain write then read
    writeTxn(8'h20, 4, 32'hDEADBEEF);
    ptrThenRead(8'h20, 4, "R7 sequential read");

    // R10 wrap in write and read
    writeTxn(8'hFE, 3, 32'h0033_2211);
    ptrThenRead(8'hFE, 3, "R10 wrap read");

    // R8 identification bank, writes ignored
    writeTxn(8'hF3, 4, 32'h5A5A_5A5A);
    ptrThenRead(8'hF2, 7, "R8 id bank read");

    // R1: start cuts a data byte after four bits; nothing may be stored
    writeTxn(8'h10, 1, 32'h0000_0077);
    busStart();
    sendByte(myAddr(0), ack);
    writeBody(8'h10, 0, 32'h0);
    sendBits(8'hAA, 4);
    busStart();
    sendByte(myAddr(1), ack);
    chk(ack, "R1 address ack after aborting start", 32'(ack), 1);
    mPtr = 8'h10;
    readBody(1, "R1 aborted byte not stored");
    busStop();

    // random mix
    for (int t = 0; t < 30; t++) begin
      strap = 2'($urandom % 4);
      op = int'($urandom % 3);
      case ($urandom % 4)
        0: p = 8'hF0 + 8'($urandom % 8);
        1: p = 8'hFC + 8'($urandom % 4);
        default: p = 8'($urandom);
      endcase
      n = 1 + int'($urandom % 4);
      d = $urandom;
      if (op == 0) writeTxn(p, n, d);
      else if (op == 1) ptrThenRead(p, n, "R7 random read");
      else readTxn(n, "R7 read continuing at pointer");
    end

    chk(r4Bad == 0, "R4 enable changed with clock high", 32'(r4Bad), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule